// File: doc/BRIEF.md
# Sequential Offset Register Loader

This block holds the two thresholds used by the almost-empty and almost-full flags of a FIFO. Each threshold is as wide as the FIFO address, `log2(DEPTH)` bits. It is stored in two registers: an 8-bit low byte and a narrower high part. Together they make four registers, which are reached one at a time through a rotating index.

On the write clock, a cycle with the load select and the write enable both high stores the input byte in the register the write index points to. The index then advances and wraps from the fourth register back to the first. Between load cycles the index is kept, so a partial load resumes at the next register.

On the read clock, a cycle with the load select and both read enables high places the next register on the output bus. The read side has its own index, which follows the same order. The load path is only open when the load select was high while reset was asserted (programmable mode). In the other mode (two-enable mode) the thresholds keep their defaults and the output bus does not move. The assembled thresholds go to the flag logic.

Top module: `ofs_loader`

## Requirements
- R1: After reset both thresholds equal 7 (low byte 07h, high part 0), `rd_data` is 0, and both indices point to the empty low byte.
- R2: In programmable mode, a `wclk` edge with `wr_en` and `ld_sel` both high writes `wr_data` to the current register, in the order empty-low (slot 0), empty-high (slot 1), full-low (slot 2), full-high (slot 3). `empty_ofs` is {slot 1, slot 0} and `full_ofs` is {slot 3, slot 2}. Both outputs update one cycle after the edge.
- R3: After a write to slot 3, the next load write goes to slot 0.
- R4: A `wclk` cycle with `wr_en` low or `ld_sel` low writes nothing and keeps the write index. The next load write goes to the following slot.
- R5: A high-part register stores only the low `log2(DEPTH)-8` bits of `wr_data`. When read back, its upper bits are 0.
- R6: In programmable mode, an `rclk` edge with `ld_sel`, `rd_en_a` and `rd_en_b` all high loads the register at the read index onto `rd_data` and advances the read index in the same order as R2. In any other read cycle, `rd_data` holds its value.
- R7: When `ld_sel` was low during reset (two-enable mode), load writes leave both thresholds at 7 and read cycles leave `rd_data` at 0.
- R8: A new reset returns both indices to slot 0, even after a partial load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Write enable, active high |
| ld_sel | input | 1 | Load select. During reset it picks the mode (high = programmable); afterwards it opens the register path |
| wr_data | input | 8 | Byte written into the current register |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_en_a | input | 1 | First read enable, active high |
| rd_en_b | input | 1 | Second read enable, active high |
| rd_data | output | 8 | Registered readback byte |
| empty_ofs | output | OFS_W | Assembled almost-empty threshold |
| full_ofs | output | OFS_W | Assembled almost-full threshold |

## Verification
Four properties are checked on every cycle:
- both indices hold on any cycle that is not a load access, and step by one on a load access;
- a low-byte load lands in the matching half of the threshold output;
- after a high-part read, the upper bits of the readback byte are zero;
- in two-enable mode the thresholds and the readback bus never move.

Only the bench scenarios can show the following:
- the write order is right end to end;
- the index wraps after slot 3;
- a paused load resumes at the correct slot;
- the readback sequence matches what was written;
- a second reset restarts a half-finished load.

// File: rtl/ofs_ldr_pkg.sv
package ofs_ldr_pkg;

  localparam int NSLOT = 4;

  typedef enum logic [1:0] {
    SLOT_ELO = 2'd0,
    SLOT_EHI = 2'd1,
    SLOT_FLO = 2'd2,
    SLOT_FHI = 2'd3
  } slot_e;

  function automatic slot_e next_slot(input slot_e s);
    return slot_e'(s + 2'd1);
  endfunction

  function automatic logic is_high_part(input slot_e s);
    return s[0];
  endfunction

endpackage

// File: rtl/ofs_wr_seq.sv
module ofs_wr_seq
  import ofs_ldr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  logic  ld_sel,
  output logic  prog_mode,
  output logic  load_stb,
  output slot_e slot
);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= SLOT_ELO;
      prog_mode <= ld_sel;
    end else if (load_stb) begin
      slot <= next_slot(slot);
    end
  end

  always_comb load_stb = prog_mode && wr_en && ld_sel;

  // R4: index is kept outside load cycles
  a_r4_slot_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && ld_sel) |=> $stable(slot));

  // R3: index steps by one and wraps
  a_r3_slot_step: assert property (@(posedge clk) disable iff (rst)
    (prog_mode && wr_en && ld_sel) |=> (slot == slot_e'($past(slot) + 2'd1)));

endmodule

// File: rtl/ofs_bank.sv
module ofs_bank
  import ofs_ldr_pkg::*;
#(
  parameter int LOW_W  = 8,
  parameter int HIGH_W = 2,
  parameter int DEF_LO = 7,
  localparam int OFS_W = LOW_W + HIGH_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_stb,
  input  slot_e                  slot,
  input  logic [LOW_W-1:0]       din,
  output logic [NSLOT*LOW_W-1:0] bank_flat,
  output logic [OFS_W-1:0]       empty_ofs,
  output logic [OFS_W-1:0]       full_ofs
);

  logic [LOW_W-1:0]  lo_q [NSLOT/2];
  logic [HIGH_W-1:0] hi_q [NSLOT/2];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam int PAIR = g / 2;
    if ((g % 2) == 0) begin : g_low
      always_ff @(posedge clk) begin
        if (rst)
          lo_q[PAIR] <= LOW_W'(DEF_LO);
        else if (load_stb && (slot == slot_e'(g)))
          lo_q[PAIR] <= din;
      end
      assign bank_flat[g*LOW_W +: LOW_W] = lo_q[PAIR];
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (rst)
          hi_q[PAIR] <= '0;
        else if (load_stb && (slot == slot_e'(g)))
          hi_q[PAIR] <= din[HIGH_W-1:0];
      end
      assign bank_flat[g*LOW_W +: LOW_W] = {{(LOW_W-HIGH_W){1'b0}}, hi_q[PAIR]};
    end
  end

  assign empty_ofs = {hi_q[0], lo_q[0]};
  assign full_ofs  = {hi_q[1], lo_q[1]};

  // R2: a low-byte load of the empty threshold lands in its low half
  a_r2_elo_lands: assert property (@(posedge clk) disable iff (rst)
    (load_stb && slot == SLOT_ELO) |=> (empty_ofs[LOW_W-1:0] == $past(din)));

  // R2: a low-byte load of the full threshold lands in its low half
  a_r2_flo_lands: assert property (@(posedge clk) disable iff (rst)
    (load_stb && slot == SLOT_FLO) |=> (full_ofs[LOW_W-1:0] == $past(din)));

endmodule

// File: rtl/ofs_rd_seq.sv
module ofs_rd_seq
  import ofs_ldr_pkg::*;
#(
  parameter int LOW_W  = 8,
  parameter int HIGH_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_en_a,
  input  logic                   rd_en_b,
  input  logic                   ld_sel,
  input  logic [NSLOT*LOW_W-1:0] bank_flat,
  output logic [LOW_W-1:0]       rd_data
);

  logic  prog_mode;
  slot_e slot;
  logic  rd_stb;

  always_comb rd_stb = prog_mode && ld_sel && rd_en_a && rd_en_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= SLOT_ELO;
      prog_mode <= ld_sel;
      rd_data   <= '0;
    end else if (rd_stb) begin
      rd_data <= bank_flat[slot*LOW_W +: LOW_W];
      slot    <= next_slot(slot);
    end
  end

  // R6: output holds outside read cycles
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (rst)
    !(ld_sel && rd_en_a && rd_en_b) |=> $stable(rd_data));

  // R6: read index holds outside read cycles
  a_r6_slot_hold: assert property (@(posedge clk) disable iff (rst)
    !(ld_sel && rd_en_a && rd_en_b) |=> $stable(slot));

  // R5: high-part readback has zero upper bits
  a_r5_hi_zero: assert property (@(posedge clk) disable iff (rst)
    (prog_mode && ld_sel && rd_en_a && rd_en_b && is_high_part(slot))
      |=> (rd_data[LOW_W-1:HIGH_W] == '0));

  // R7: in two-enable mode the readback bus stays at zero
  a_r7_rd_fixed: assert property (@(posedge clk) disable iff (rst)
    !prog_mode |-> (rd_data == '0));

endmodule

// File: rtl/ofs_loader.sv
module ofs_loader
  import ofs_ldr_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LOW_W  = 8,
  parameter int DEF_LO = 7,
  parameter int OFS_W  = $clog2(DEPTH)
) (
  input  logic             wclk,
  input  logic             wrst,
  input  logic             wr_en,
  input  logic             ld_sel,
  input  logic [LOW_W-1:0] wr_data,
  input  logic             rclk,
  input  logic             rrst,
  input  logic             rd_en_a,
  input  logic             rd_en_b,
  output logic [LOW_W-1:0] rd_data,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);

  localparam int HIGH_W = OFS_W - LOW_W;

  logic                   wprog;
  logic                   load_stb;
  slot_e                  wslot;
  logic [NSLOT*LOW_W-1:0] bank_flat;

  ofs_wr_seq u_wr (
    .clk       (wclk),
    .rst       (wrst),
    .wr_en     (wr_en),
    .ld_sel    (ld_sel),
    .prog_mode (wprog),
    .load_stb  (load_stb),
    .slot      (wslot)
  );

  ofs_bank #(
    .LOW_W  (LOW_W),
    .HIGH_W (HIGH_W),
    .DEF_LO (DEF_LO)
  ) u_bank (
    .clk       (wclk),
    .rst       (wrst),
    .load_stb  (load_stb),
    .slot      (wslot),
    .din       (wr_data),
    .bank_flat (bank_flat),
    .empty_ofs (empty_ofs),
    .full_ofs  (full_ofs)
  );

  ofs_rd_seq #(
    .LOW_W  (LOW_W),
    .HIGH_W (HIGH_W)
  ) u_rd (
    .clk       (rclk),
    .rst       (rrst),
    .rd_en_a   (rd_en_a),
    .rd_en_b   (rd_en_b),
    .ld_sel    (ld_sel),
    .bank_flat (bank_flat),
    .rd_data   (rd_data)
  );

  // R7: thresholds never move in two-enable mode
  a_r7_fixed_hold: assert property (@(posedge wclk) disable iff (wrst)
    !wprog |=> ($stable(empty_ofs) && $stable(full_ofs)));

  // R1: the width split must leave a high part narrower than a byte
  initial begin
    a_r1_width_ok: assert (HIGH_W >= 1 && HIGH_W < LOW_W);
  end

endmodule

// File: tb/ofs_loader_bench.sv
module ofs_loader_bench;

  localparam int DEPTH = 1024;
  localparam int OFS_W = $clog2(DEPTH);
  localparam int HIGH_W = OFS_W - 8;
  localparam logic [7:0] HMASK = 8'((1 << HIGH_W) - 1);

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst = 1'b1, rrst = 1'b1;
  logic wr_en = 1'b0, ld_sel = 1'b1;
  logic rd_en_a = 1'b0, rd_en_b = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [OFS_W-1:0] empty_ofs, full_ofs;

  int n_cmp = 0, n_bad = 0;

  logic [7:0] m [4];
  int widx, ridx;
  logic wprog, rprog;
  logic [7:0] exp_q;

  always #5 wclk = ~wclk;
  initial begin
    #2;
    forever #5 rclk = ~rclk;
  end

  ofs_loader #(.DEPTH(DEPTH)) u_ofs_loader (
    .wclk(wclk), .wrst(wrst), .wr_en(wr_en), .ld_sel(ld_sel), .wr_data(wr_data),
    .rclk(rclk), .rrst(rrst), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .rd_data(rd_data), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  function automatic logic [OFS_W-1:0] exp_empty();
    return {m[1][HIGH_W-1:0], m[0]};
  endfunction

  function automatic logic [OFS_W-1:0] exp_full();
    return {m[3][HIGH_W-1:0], m[2]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic prog);
    @(negedge wclk);
    wrst = 1'b1; rrst = 1'b1; ld_sel = prog;
    wr_en = 1'b0; rd_en_a = 1'b0; rd_en_b = 1'b0;
    repeat (3) @(posedge wclk);
    @(posedge rclk);
    @(negedge wclk);
    wrst = 1'b0; rrst = 1'b0; ld_sel = 1'b0;
    m[0] = 8'd7; m[1] = 8'd0; m[2] = 8'd7; m[3] = 8'd0;
    widx = 0; ridx = 0; wprog = prog; rprog = prog; exp_q = '0;
    #1;
    chk("R1 empty_ofs after reset", 32'(empty_ofs), 32'(exp_empty()));
    chk("R1 full_ofs after reset", 32'(full_ofs), 32'(exp_full()));
    chk("R1 rd_data after reset", 32'(rd_data), 32'(exp_q));
  endtask

  task automatic wr_cycle(input logic en, input logic ld, input logic [7:0] d, input string tag);
    @(negedge wclk);
    wr_en = en; ld_sel = ld; wr_data = d; rd_en_a = 1'b0; rd_en_b = 1'b0;
    @(posedge wclk);
    #1;
    wr_en = 1'b0;
    if (wprog && en && ld) begin
      m[widx] = (widx % 2 == 1) ? (d & HMASK) : d;
      widx = (widx + 1) % 4;
    end
    chk({tag, " empty_ofs"}, 32'(empty_ofs), 32'(exp_empty()));
    chk({tag, " full_ofs"}, 32'(full_ofs), 32'(exp_full()));
  endtask

  task automatic rd_cycle(input logic a, input logic b, input logic ld, input string tag);
    @(negedge rclk);
    rd_en_a = a; rd_en_b = b; ld_sel = ld; wr_en = 1'b0;
    @(posedge rclk);
    #1;
    rd_en_a = 1'b0; rd_en_b = 1'b0;
    if (rprog && a && b && ld) begin
      exp_q = m[ridx];
      ridx = (ridx + 1) % 4;
    end
    chk({tag, " rd_data"}, 32'(rd_data), 32'(exp_q));
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A17));

    // R1: reset state in programmable mode
    do_reset(1'b1);

    // R2, R5: load all four slots in order
    wr_cycle(1'b1, 1'b1, 8'hA5, "R2 slot0");
    wr_cycle(1'b1, 1'b1, 8'hFF, "R5 slot1 masked");
    wr_cycle(1'b1, 1'b1, 8'h3C, "R2 slot2");
    wr_cycle(1'b1, 1'b1, 8'h06, "R2 slot3");
    // R3: wrap back to slot 0
    wr_cycle(1'b1, 1'b1, 8'h11, "R3 wrap to slot0");
    // R4: pauses keep the index
    wr_cycle(1'b1, 1'b0, 8'h77, "R4 normal write");
    wr_cycle(1'b0, 1'b1, 8'h88, "R4 enable low");
    wr_cycle(1'b1, 1'b1, 8'hFE, "R4 resume slot1");

    // R6, R5: readback sequence
    rd_cycle(1'b1, 1'b1, 1'b1, "R6 read slot0");
    rd_cycle(1'b1, 1'b1, 1'b1, "R5 read slot1");
    rd_cycle(1'b1, 1'b0, 1'b1, "R6 hold one enable");
    rd_cycle(1'b1, 1'b1, 1'b0, "R6 hold no load");
    rd_cycle(1'b1, 1'b1, 1'b1, "R6 read slot2");
    rd_cycle(1'b1, 1'b1, 1'b1, "R5 read slot3");
    rd_cycle(1'b1, 1'b1, 1'b1, "R6 read wrap slot0");

    // R8: reset after partial load restarts both indices
    wr_cycle(1'b1, 1'b1, 8'h5A, "R8 partial load");
    rd_cycle(1'b1, 1'b1, 1'b1, "R8 partial read");
    do_reset(1'b1);
    wr_cycle(1'b1, 1'b1, 8'hC3, "R8 first write after reset");
    rd_cycle(1'b1, 1'b1, 1'b1, "R8 first read after reset");

    // R7: two-enable mode keeps defaults
    do_reset(1'b0);
    for (int i = 0; i < 6; i++) wr_cycle(1'b1, 1'b1, 8'(8'h90 + i), "R7 load ignored");
    for (int i = 0; i < 4; i++) rd_cycle(1'b1, 1'b1, 1'b1, "R7 read ignored");

    // R2, R6: random mix in programmable mode
    do_reset(1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[0])
        wr_cycle(r[1] | r[2], r[3] | r[4], r[15:8], "R2 random write");
      else
        rd_cycle(r[1] | r[5], r[2] | r[6], r[3] | r[4], "R6 random read");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule